// File: doc/BRIEF.md
# Keyed Hash Finalizer with Lane Shuffle

This block closes a keyed multiply-and-permute hash. It receives the 1024-bit mixing state (four 256-bit registers, each made of four 64-bit lanes) once every whole 32-byte packet has been absorbed, together with the count of trailing message bytes modulo 32. It first folds that 5-bit tail count into the state. It then runs a fixed number of closing rounds and collapses the four registers into a 256-bit digest. The low 64-bit lane of that digest is also presented on its own port.

Each closing round feeds the round function with a packet built from the first mix register. That packet swaps the two 128-bit halves and the two 32-bit halves of every 64-bit lane. The round function has its own copy inside the block and is evaluated in one clock. A start strobe loads the state. A one-cycle done strobe announces the digest, which then holds until the next result is produced.

Top module: `keyed_hash_finalizer`

## Requirements
- R1: While reset is high, and on the first cycle after it, done is 0 and both digest outputs are 0.
- R2: On an accepted start, the tail length (0..31, zero-extended) is added modulo 2^32 to each of the eight 32-bit sub-words of mix_x. Sub-word 0 is bits 31:0 of lane 0, and lane k occupies bits 64k+63:64k. The add is done even when the tail length is 0.
- R3: On an accepted start, each 32-bit sub-word of mix_y is rotated left by the tail length. A tail length of 0 leaves mix_y unchanged.
- R4: The packet of every closing round is taken from mix_x. Packet lane k is mix_x lane (k XOR 2) with its upper and lower 32-bit halves exchanged.
- R5: One round updates each lane in this order. First y += packet + prd_x. Then prd_x ^= y[31:0]*x[63:32], using the x value from before this round. Then x += prd_y, and prd_y ^= x[31:0]*y[63:32]. Then x += interleave(y), and finally y += interleave(x). All arithmetic is modulo 2^64.
- R6: The interleave works on lane pairs (0,1) and (2,3), treated as 16 bytes with byte 0 at bit 0 of the even lane. Result bytes 0..15 come from source bytes 3,12,2,5,14,1,15,0,11,4,10,13,9,6,8,7.
- R7: Exactly four closing rounds are run. done goes high after the sixth rising edge, counting the edge that samples start as the first.
- R8: Digest lane k is the sum modulo 2^64 of lane k of mix_x, mix_y, prd_x and prd_y after the last round. digest_lo always equals digest lane 0.
- R9: done is high for exactly one cycle. The digest outputs change only in the cycle where done rises.
- R10: A start raised while a digest is being computed is ignored.
- R11: A start raised in the same cycle that done is high is accepted, and its digest follows with the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the state and tail length, then begin finalizing |
| in_mix_x | input | 256 | First mix register, four 64-bit lanes |
| in_mix_y | input | 256 | Second mix register |
| in_prd_x | input | 256 | First product accumulator |
| in_prd_y | input | 256 | Second product accumulator |
| tail_len | input | 5 | Message length modulo 32 |
| done | output | 1 | One-cycle strobe: digest is valid |
| digest | output | 256 | Four-lane digest |
| digest_lo | output | 64 | Lane 0 of the digest |

## Verification
The done strobe of one digest and the start of the next can fall in the same cycle. This happens because the block goes idle in the cycle its done is visible. The bench provokes it by raising start in exactly the cycle where done is sampled high, using a second, different state. It then judges two things. First, the earlier digest must stay on the outputs with done low for the whole new computation. Second, the new digest must appear after the normal six-edge latency and match the value computed independently from the requirements.

// File: rtl/khf_pkg.sv
package khf_pkg;
  localparam int LANE_W_D = 64;
  localparam int NLANES_D = 4;
  localparam int ROUNDS_D = 4;
  localparam int LEN_W_D  = 5;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_MIX  = 2'd1,
    FS_FOLD = 2'd2
  } fin_state_e;

  // Source byte for each destination byte of a 16-byte lane pair.
  function automatic int pick_byte(input int dst);
    case (dst)
      0:  pick_byte = 3;
      1:  pick_byte = 12;
      2:  pick_byte = 2;
      3:  pick_byte = 5;
      4:  pick_byte = 14;
      5:  pick_byte = 1;
      6:  pick_byte = 15;
      7:  pick_byte = 0;
      8:  pick_byte = 11;
      9:  pick_byte = 4;
      10: pick_byte = 10;
      11: pick_byte = 13;
      12: pick_byte = 9;
      13: pick_byte = 6;
      14: pick_byte = 8;
      15: pick_byte = 7;
      default: pick_byte = 0;
    endcase
  endfunction
endpackage

// File: rtl/khf_interleave.sv
module khf_interleave #(
  parameter int LANE_W = khf_pkg::LANE_W_D
) (
  input  logic [LANE_W-1:0] lo_i,
  input  logic [LANE_W-1:0] hi_i,
  output logic [LANE_W-1:0] lo_o,
  output logic [LANE_W-1:0] hi_o
);
  localparam int NB = (2 * LANE_W) / 8;

  logic [2*LANE_W-1:0] src;
  logic [2*LANE_W-1:0] dst;

  assign src = {hi_i, lo_i};

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int SRC = khf_pkg::pick_byte(b);
    assign dst[8*b +: 8] = src[8*SRC +: 8];
  end

  assign lo_o = dst[LANE_W-1:0];
  assign hi_o = dst[2*LANE_W-1:LANE_W];
endmodule

// File: rtl/khf_len_inject.sv
module khf_len_inject #(
  parameter int LANE_W = khf_pkg::LANE_W_D,
  parameter int NLANES = khf_pkg::NLANES_D,
  parameter int LEN_W  = khf_pkg::LEN_W_D
) (
  input  logic [NLANES*LANE_W-1:0] x_i,
  input  logic [NLANES*LANE_W-1:0] y_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [NLANES*LANE_W-1:0] x_o,
  output logic [NLANES*LANE_W-1:0] y_o
);
  localparam int SUB_W = LANE_W / 2;
  localparam int NSUB  = 2 * NLANES;
  localparam int SH_W  = $clog2(SUB_W) + 1;

  logic [SUB_W-1:0] len_ext;
  logic [SH_W-1:0]  rsh;

  assign len_ext = {{(SUB_W-LEN_W){1'b0}}, len_i};
  // Right-shift partner of the left rotate; equals SUB_W when len is 0.
  assign rsh = SH_W'(SUB_W) - {{(SH_W-LEN_W){1'b0}}, len_i};

  for (genvar j = 0; j < NSUB; j++) begin : g_sub
    logic [SUB_W-1:0] xw;
    logic [SUB_W-1:0] yw;
    assign xw = x_i[j*SUB_W +: SUB_W];
    assign yw = y_i[j*SUB_W +: SUB_W];
    assign x_o[j*SUB_W +: SUB_W] = xw + len_ext;
    assign y_o[j*SUB_W +: SUB_W] = (yw << len_i) | (yw >> rsh);
  end
endmodule

// File: rtl/khf_round.sv
module khf_round #(
  parameter int LANE_W = khf_pkg::LANE_W_D,
  parameter int NLANES = khf_pkg::NLANES_D
) (
  input  logic [NLANES*LANE_W-1:0] x_i,
  input  logic [NLANES*LANE_W-1:0] y_i,
  input  logic [NLANES*LANE_W-1:0] px_i,
  input  logic [NLANES*LANE_W-1:0] py_i,
  input  logic [NLANES*LANE_W-1:0] pkt_i,
  output logic [NLANES*LANE_W-1:0] x_o,
  output logic [NLANES*LANE_W-1:0] y_o,
  output logic [NLANES*LANE_W-1:0] px_o,
  output logic [NLANES*LANE_W-1:0] py_o
);
  localparam int SUB_W  = LANE_W / 2;
  localparam int VEC_W  = NLANES * LANE_W;
  localparam int NPAIRS = NLANES / 2;

  logic [VEC_W-1:0] y_a;
  logic [VEC_W-1:0] x_a;
  logic [VEC_W-1:0] x_b;
  logic [VEC_W-1:0] zy;
  logic [VEC_W-1:0] zx;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    localparam int B = l * LANE_W;
    logic [LANE_W-1:0] mul_a;
    logic [LANE_W-1:0] mul_b;

    assign y_a[B +: LANE_W] = y_i[B +: LANE_W] + pkt_i[B +: LANE_W] + px_i[B +: LANE_W];
    assign mul_a = {{SUB_W{1'b0}}, y_a[B +: SUB_W]} *
                   {{SUB_W{1'b0}}, x_i[B+SUB_W +: SUB_W]};
    assign px_o[B +: LANE_W] = px_i[B +: LANE_W] ^ mul_a;

    assign x_a[B +: LANE_W] = x_i[B +: LANE_W] + py_i[B +: LANE_W];
    assign mul_b = {{SUB_W{1'b0}}, x_a[B +: SUB_W]} *
                   {{SUB_W{1'b0}}, y_a[B+SUB_W +: SUB_W]};
    assign py_o[B +: LANE_W] = py_i[B +: LANE_W] ^ mul_b;

    assign x_b[B +: LANE_W] = x_a[B +: LANE_W] + zy[B +: LANE_W];
    assign y_o[B +: LANE_W] = y_a[B +: LANE_W] + zx[B +: LANE_W];
    assign x_o[B +: LANE_W] = x_b[B +: LANE_W];
  end

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam int LO = (2 * p) * LANE_W;
    localparam int HI = (2 * p + 1) * LANE_W;

    khf_interleave #(.LANE_W(LANE_W)) u_mix_y (
      .lo_i (y_a[LO +: LANE_W]),
      .hi_i (y_a[HI +: LANE_W]),
      .lo_o (zy[LO +: LANE_W]),
      .hi_o (zy[HI +: LANE_W])
    );

    khf_interleave #(.LANE_W(LANE_W)) u_mix_x (
      .lo_i (x_b[LO +: LANE_W]),
      .hi_i (x_b[HI +: LANE_W]),
      .lo_o (zx[LO +: LANE_W]),
      .hi_o (zx[HI +: LANE_W])
    );
  end
endmodule

// File: rtl/khf_fold.sv
module khf_fold #(
  parameter int LANE_W = khf_pkg::LANE_W_D,
  parameter int NLANES = khf_pkg::NLANES_D
) (
  input  logic [NLANES*LANE_W-1:0] a_i,
  input  logic [NLANES*LANE_W-1:0] b_i,
  input  logic [NLANES*LANE_W-1:0] c_i,
  input  logic [NLANES*LANE_W-1:0] d_i,
  output logic [NLANES*LANE_W-1:0] sum_o
);
  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    localparam int B = l * LANE_W;
    assign sum_o[B +: LANE_W] = a_i[B +: LANE_W] + b_i[B +: LANE_W]
                              + c_i[B +: LANE_W] + d_i[B +: LANE_W];
  end
endmodule

// File: rtl/keyed_hash_finalizer.sv
module keyed_hash_finalizer #(
  parameter int LANE_W = khf_pkg::LANE_W_D,
  parameter int NLANES = khf_pkg::NLANES_D,
  parameter int ROUNDS = khf_pkg::ROUNDS_D,
  parameter int LEN_W  = khf_pkg::LEN_W_D
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NLANES*LANE_W-1:0] in_mix_x,
  input  logic [NLANES*LANE_W-1:0] in_mix_y,
  input  logic [NLANES*LANE_W-1:0] in_prd_x,
  input  logic [NLANES*LANE_W-1:0] in_prd_y,
  input  logic [LEN_W-1:0]         tail_len,
  output logic                     done,
  output logic [NLANES*LANE_W-1:0] digest,
  output logic [LANE_W-1:0]        digest_lo
);
  import khf_pkg::*;

  localparam int VEC_W = NLANES * LANE_W;
  localparam int SUB_W = LANE_W / 2;
  localparam int HALF  = NLANES / 2;
  localparam int RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  fin_state_e       st_q;
  logic [RND_W-1:0] rnd_q;
  logic [VEC_W-1:0] mx_q, my_q, px_q, py_q;

  logic [VEC_W-1:0] inj_x, inj_y;
  logic [VEC_W-1:0] pkt;
  logic [VEC_W-1:0] nx_x, nx_y, nx_px, nx_py;
  logic [VEC_W-1:0] folded;

  khf_len_inject #(.LANE_W(LANE_W), .NLANES(NLANES), .LEN_W(LEN_W)) u_inject (
    .x_i   (in_mix_x),
    .y_i   (in_mix_y),
    .len_i (tail_len),
    .x_o   (inj_x),
    .y_o   (inj_y)
  );

  // Packet: partner lane across the 128-bit halves, 32-bit halves exchanged.
  for (genvar l = 0; l < NLANES; l++) begin : g_pkt
    localparam int SRC = (l ^ HALF) * LANE_W;
    assign pkt[l*LANE_W +: LANE_W] = {mx_q[SRC +: SUB_W], mx_q[SRC+SUB_W +: SUB_W]};
  end

  khf_round #(.LANE_W(LANE_W), .NLANES(NLANES)) u_round (
    .x_i   (mx_q),
    .y_i   (my_q),
    .px_i  (px_q),
    .py_i  (py_q),
    .pkt_i (pkt),
    .x_o   (nx_x),
    .y_o   (nx_y),
    .px_o  (nx_px),
    .py_o  (nx_py)
  );

  khf_fold #(.LANE_W(LANE_W), .NLANES(NLANES)) u_fold (
    .a_i   (mx_q),
    .b_i   (my_q),
    .c_i   (px_q),
    .d_i   (py_q),
    .sum_o (folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= FS_IDLE;
      rnd_q     <= '0;
      mx_q      <= '0;
      my_q      <= '0;
      px_q      <= '0;
      py_q      <= '0;
      done      <= 1'b0;
      digest    <= '0;
      digest_lo <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        FS_IDLE: begin
          if (start) begin
            mx_q  <= inj_x;
            my_q  <= inj_y;
            px_q  <= in_prd_x;
            py_q  <= in_prd_y;
            rnd_q <= '0;
            st_q  <= FS_MIX;
          end
        end
        FS_MIX: begin
          mx_q <= nx_x;
          my_q <= nx_y;
          px_q <= nx_px;
          py_q <= nx_py;
          if (rnd_q == LAST_RND) begin
            st_q <= FS_FOLD;
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end
        FS_FOLD: begin
          digest    <= folded;
          digest_lo <= folded[LANE_W-1:0];
          done      <= 1'b1;
          st_q      <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/khf_checker.sv
module khf_checker #(
  parameter int LANE_W = khf_pkg::LANE_W_D,
  parameter int NLANES = khf_pkg::NLANES_D,
  parameter int ROUNDS = khf_pkg::ROUNDS_D
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start,
  input logic                     done,
  input logic [NLANES*LANE_W-1:0] digest,
  input logic [LANE_W-1:0]        digest_lo
);
  localparam int LAT = ROUNDS + 2;
  localparam int CW  = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  // Independent latency tracker built only from start and the fixed schedule.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if ((cnt == '0 || cnt == CW'(LAT)) && start) begin
      cnt <= CW'(1);
    end else if (cnt == CW'(LAT)) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!done && digest == '0 && digest_lo == '0));

  // R7, R10, R11: done appears exactly at the scheduled edge, never otherwise.
  assert_done_latency_R7: assert property (@(posedge clk) disable iff (rst)
    done == (cnt == CW'(LAT)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_digest_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(digest));

  assert_low_lane_R8: assert property (@(posedge clk) disable iff (rst)
    digest_lo == digest[LANE_W-1:0]);
endmodule

bind keyed_hash_finalizer khf_checker #(
  .LANE_W (LANE_W),
  .NLANES (NLANES),
  .ROUNDS (ROUNDS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .done      (done),
  .digest    (digest),
  .digest_lo (digest_lo)
);

// File: tb/keyed_hash_finalizer_bench.sv
module keyed_hash_finalizer_bench;
  localparam int LW   = 64;
  localparam int NL   = 4;
  localparam int VW   = NL * LW;
  localparam int RNDS = 4;
  localparam int LAT  = RNDS + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [VW-1:0] i_x = '0, i_y = '0, i_px = '0, i_py = '0;
  logic [4:0]    tl = '0;
  logic          done;
  logic [VW-1:0] dg;
  logic [LW-1:0] dlo;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] seed = 64'h0123_4567_89ab_cdef;

  always #5 clk = ~clk;

  keyed_hash_finalizer u_keyed_hash_finalizer (
    .clk(clk), .rst(rst), .start(start),
    .in_mix_x(i_x), .in_mix_y(i_y), .in_prd_x(i_px), .in_prd_y(i_py),
    .tail_len(tl), .done(done), .digest(dg), .digest_lo(dlo)
  );

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] nxt();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [VW-1:0] rnd256();
    return {nxt(), nxt(), nxt(), nxt()};
  endfunction

  // R6 byte interleave on a 16-byte lane pair.
  function automatic logic [127:0] zip128(input logic [127:0] s);
    int src [16] = '{3, 12, 2, 5, 14, 1, 15, 0, 11, 4, 10, 13, 9, 6, 8, 7};
    logic [127:0] r;
    for (int d = 0; d < 16; d++) r[8*d +: 8] = s[8*src[d] +: 8];
    return r;
  endfunction

  // Expected digest from R2..R8.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] x, y, px, py,
                                          input logic [4:0] r);
    logic [63:0]  a [4];
    logic [63:0]  b [4];
    logic [63:0]  c [4];
    logic [63:0]  d [4];
    logic [63:0]  p [4];
    logic [31:0]  w;
    logic [127:0] z;
    logic [VW-1:0] res;
    for (int i = 0; i < 4; i++) begin
      a[i] = x[64*i +: 64]; b[i] = y[64*i +: 64];
      c[i] = px[64*i +: 64]; d[i] = py[64*i +: 64];
      for (int h = 0; h < 2; h++) begin
        w = a[i][32*h +: 32];
        a[i][32*h +: 32] = w + 32'(r);
        w = b[i][32*h +: 32];
        b[i][32*h +: 32] = (r == 5'd0) ? w : ((w << r) | (w >> (32 - int'(r))));
      end
    end
    for (int rd = 0; rd < RNDS; rd++) begin
      for (int i = 0; i < 4; i++) p[i] = {a[i^2][31:0], a[i^2][63:32]};
      for (int i = 0; i < 4; i++) begin
        b[i] = b[i] + p[i] + c[i];
        c[i] = c[i] ^ (64'(b[i][31:0]) * 64'(a[i][63:32]));
        a[i] = a[i] + d[i];
        d[i] = d[i] ^ (64'(a[i][31:0]) * 64'(b[i][63:32]));
      end
      for (int q = 0; q < 2; q++) begin
        z = zip128({b[2*q+1], b[2*q]});
        a[2*q] = a[2*q] + z[63:0];
        a[2*q+1] = a[2*q+1] + z[127:64];
        z = zip128({a[2*q+1], a[2*q]});
        b[2*q] = b[2*q] + z[63:0];
        b[2*q+1] = b[2*q+1] + z[127:64];
      end
    end
    for (int i = 0; i < 4; i++) res[64*i +: 64] = a[i] + b[i] + c[i] + d[i];
    return res;
  endfunction

  // Drive one start and wait for done; lat counts edges from the sampling edge.
  task automatic run(input logic [VW-1:0] x, y, px, py, input logic [4:0] r,
                     output logic [VW-1:0] got, output int lat);
    @(negedge clk);
    i_x = x; i_y = y; i_px = px; i_py = py; tl = r; start = 1'b1;
    lat = 99;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (done) begin lat = k; break; end
    end
    got = dg;
  endtask

  task automatic check_run(input string tag, input logic [VW-1:0] x, y, px, py,
                           input logic [4:0] r);
    logic [VW-1:0] got, exp;
    int lat;
    exp = model(x, y, px, py, r);
    run(x, y, px, py, r, got, lat);
    chk(got == exp, tag, got, exp);
    chk(dlo == exp[63:0], {tag, " R8 low lane"}, VW'(dlo), VW'(exp[63:0]));
    chk(lat == LAT, {tag, " R7 latency"}, VW'(lat), VW'(LAT));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b0, "R1 done in reset", VW'(done), '0);
    chk(dg == '0, "R1 digest in reset", dg, '0);
    chk(dlo == '0, "R1 low digest in reset", VW'(dlo), '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk(done == 1'b0 && dg == '0, "R1 first cycle after reset", dg, '0);
  endtask

  task automatic t_zero();
    logic [VW-1:0] got;
    int lat;
    run('0, '0, '0, '0, 5'd0, got, lat);
    chk(got == '0, "R5 all-zero state gives zero digest", got, '0);
    chk(lat == LAT, "R7 latency zero state", VW'(lat), VW'(LAT));
    @(posedge clk); #1;
    chk(done == 1'b0, "R9 done single cycle", VW'(done), '0);
  endtask

  task automatic t_patterns();
    logic [VW-1:0] rx, ry;
    rx = rnd256(); ry = rnd256();
    check_run("R5 random state", rx, ry, rnd256(), rnd256(), 5'd9);
    check_run("R4 single bit lane 3 of mix_x", VW'(1) << (3*64 + 40), '0, '0, '0, 5'd0);
    check_run("R6 single byte lane 1 of mix_y", '0, VW'(8'ha5) << (64 + 24), '0, '0, 5'd0);
    check_run("R5 all ones", '1, '1, '1, '1, 5'd31);
    check_run("R4 products only", '0, '0, rx, ry, 5'd4);
  endtask

  task automatic t_tail();
    logic [VW-1:0] x, y, px, py, g0, g1;
    int lat;
    x = rnd256(); y = rnd256(); px = rnd256(); py = rnd256();
    check_run("R2 tail 0", x, y, px, py, 5'd0);
    check_run("R3 tail 1", x, y, px, py, 5'd1);
    check_run("R3 tail 16", x, y, px, py, 5'd16);
    check_run("R2 tail 31", x, y, px, py, 5'd31);
    check_run("R3 rotate only, mix_x zero", '0, y, '0, '0, 5'd13);
    run('0, '0, '0, '0, 5'd0, g0, lat);
    run('0, '0, '0, '0, 5'd1, g1, lat);
    chk(g0 != g1, "R2 tail add applied to zero state", g1, ~g0);
    chk(g1 == model('0, '0, '0, '0, 5'd1), "R2 tail 1 on zero state", g1,
        model('0, '0, '0, '0, 5'd1));
  endtask

  task automatic t_busy();
    logic [VW-1:0] ax, ay, bx, exp;
    int seen;
    int lat;
    ax = rnd256(); ay = rnd256(); bx = rnd256();
    exp = model(ax, ay, '0, '0, 5'd3);
    @(negedge clk);
    i_x = ax; i_y = ay; i_px = '0; i_py = '0; tl = 5'd3; start = 1'b1;
    lat = 99;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      start = (k == 2);
      if (k == 2) begin i_x = bx; tl = 5'd7; end
      if (done) begin lat = k; break; end
    end
    start = 1'b0;
    chk(dg == exp, "R10 busy start ignored, digest", dg, exp);
    chk(lat == LAT, "R10 busy start ignored, latency", VW'(lat), VW'(LAT));
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      if (done) seen++;
    end
    chk(seen == 0, "R10 no extra done after ignored start", VW'(seen), '0);
  endtask

  task automatic t_back_to_back();
    logic [VW-1:0] ax, bx, by, ea, eb, got;
    int lat;
    bit hold_ok;
    ax = rnd256(); bx = rnd256(); by = rnd256();
    ea = model(ax, '0, '0, '0, 5'd5);
    eb = model(bx, by, '0, '0, 5'd22);
    run(ax, '0, '0, '0, 5'd5, got, lat);
    chk(got == ea, "R11 first digest", got, ea);
    i_x = bx; i_y = by; i_px = '0; i_py = '0; tl = 5'd22; start = 1'b1;
    hold_ok = 1'b1;
    lat = 99;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (done) begin lat = k; break; end
      if (dg != ea) hold_ok = 1'b0;
    end
    chk(hold_ok, "R9 digest held until next done", dg, ea);
    chk(lat == LAT, "R11 start with done accepted, latency", VW'(lat), VW'(LAT));
    chk(dg == eb, "R11 second digest", dg, eb);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_patterns();
    t_tail();
    t_busy();
    t_back_to_back();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog act=no completion exp=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule